// File: doc/BRIEF.md
# Per-Phase Transient Duty Equaliser

This block sits between the loop compensator of a multiphase buck controller and its PWM modulator. It receives one common duty command and produces a separate duty command for each of up to `NPH` phases. While the number of running phases stays fixed, every running phase gets the common command unchanged and every stopped phase gets zero.

The phase count changes by one at a time. A request to add or remove a phase arrives on an event input and is held until the modulator's next period strobe. At that strobe the new count takes effect. The common command present at that strobe is latched as the base, and a correction window opens. During the window each running phase gets the base plus its own signed offset. The offsets come from a table row chosen by the transition.

Table contents are written through a small write port. Normally the row for an added phase raises the new phase above the base and lowers the phases already running. When an offset would drive any running phase below zero, the correction is spread over 2 or 4 switching periods. After the last period the block returns to pass-through.

Top module: `duty_equaliser`

## Requirements
- R1: After reset the phase count is 1, the block is in pass-through, phase 0 outputs `dss_i`, and all other phases output 0.
- R2: Outside a correction window, each phase whose index is below `ph_cnt_o` outputs `dss_i` in the same cycle. A phase whose index is at or above `ph_cnt_o` outputs 0 at all times.
- R3: A pulse on `chg_i` with `chg_up_i`=1 requests count+1, and with `chg_up_i`=0 requests count-1. A request that would leave the range 1..`NPH` is dropped. An accepted request changes nothing until the first cycle with `pwm_tick_i`=1 in which no window is open. On that clock edge `ph_cnt_o` takes the new value and the window opens.
- R4: A write with `tbl_we_i`=1 stores the signed value `tbl_val_i` at the row `tbl_row_i` and phase `tbl_ph_i`. A change that adds a phase from count k uses row k-1. A change that removes a phase from count k uses row `NPH`+k-3. Reset clears every entry to 0.
- R5: In a one-period window, each running phase outputs base + its table offset. The base is the value of `dss_i` in the opening strobe cycle, and later changes of `dss_i` do not affect the window's outputs.
- R6: The window length is 2^s periods. s is the smallest value in 0..`MAXSH` for which base + (offset >>> s) >= 0 holds for every running phase under the new count, and s is `MAXSH` if no value qualifies. Every period except the last adds offset >>> s. The last period adds offset - (2^s-1)*(offset >>> s).
- R7: Each duty computed in a window is clamped to the range 0..2^`DW`-1.
- R8: The window moves to its next period only on a `pwm_tick_i` cycle. The strobe that ends the last period returns the block to pass-through.
- R9: A second request that arrives while one is still pending is dropped. A request that arrives during a window is held. It starts at the first strobe after the strobe that closes that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_tick_i | input | 1 | One-cycle pulse from the modulator at each switching-period boundary |
| dss_i | input | DW | Common steady-state duty command from the compensator |
| chg_i | input | 1 | Phase-count change request pulse |
| chg_up_i | input | 1 | Direction of the request: 1 adds a phase, 0 removes one |
| tbl_we_i | input | 1 | Offset table write enable |
| tbl_row_i | input | RW | Table row (transition) to write |
| tbl_ph_i | input | PW | Phase column to write |
| tbl_val_i | input | OW | Signed offset value to write |
| duty_o | output | NPH*DW | Per-phase duty commands, phase p at bits p*DW +: DW |
| ph_cnt_o | output | CW | Current number of running phases |

## Verification
The assertions assume that `pwm_tick_i` is a single-cycle pulse and that requests are single-cycle pulses. They also assume that the offset table is not rewritten while a window is open. The stimulus drives each strobe and request as a one-cycle pulse on the falling edge. It writes the table only while the block is in pass-through with nothing pending. The sweep moves through every transition row, from 1 phase up to `NPH` and back down to 1, over a spread of base duties. The spread reaches the single-period case, both split lengths, and both clamps. It also includes requests above the top count and below the bottom count, which must be dropped.

// File: rtl/deq_pkg.sv
package deq_pkg;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_e;

    // Table row used for a one-step change starting from count cnt.
    function automatic int trans_row(bit up, int cnt, int nph);
        return up ? (cnt - 1) : (nph + cnt - 3);
    endfunction

    function automatic int clamp_duty(int v, int hi);
        if (v < 0)  return 0;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/deq_table.sv
module deq_table #(
    parameter int NPH = 4,
    parameter int OW  = 10,
    parameter int NTR = 6,
    parameter int RW  = 3,
    parameter int PW  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we_i,
    input  logic [RW-1:0]       wr_row_i,
    input  logic [PW-1:0]       wr_ph_i,
    input  logic [OW-1:0]       wr_val_i,
    input  logic [RW-1:0]       rd_row_i,
    output logic [NPH*OW-1:0]   rd_data_o
);
    logic [OW-1:0] mem [NTR][NPH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NTR; r++)
                for (int p = 0; p < NPH; p++)
                    mem[r][p] <= '0;
        end else if (we_i && int'(wr_row_i) < NTR && int'(wr_ph_i) < NPH) begin
            mem[wr_row_i][wr_ph_i] <= wr_val_i;
        end
    end

    for (genvar p = 0; p < NPH; p++) begin : g_rd
        assign rd_data_o[p*OW +: OW] = mem[rd_row_i][p];
    end
endmodule

// File: rtl/deq_ctrl.sv
module deq_ctrl
    import deq_pkg::*;
#(
    parameter int NPH   = 4,
    parameter int DW    = 10,
    parameter int CW    = 3,
    parameter int RW    = 3,
    parameter int SW    = 2,
    parameter int MAXSH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_i,
    input  logic            chg_i,
    input  logic            chg_up_i,
    input  logic [DW-1:0]   dss_i,
    input  logic [SW-1:0]   fit_sh_i,
    output logic [CW-1:0]   cnt_o,
    output logic [CW-1:0]   cand_cnt_o,
    output logic [RW-1:0]   row_o,
    output logic            run_o,
    output logic [SW-1:0]   sh_o,
    output logic            last_o,
    output logic [DW-1:0]   base_o
);
    localparam int PCW = (MAXSH < 1) ? 1 : MAXSH;

    win_e           st_q;
    logic           pend_q, pend_up_q;
    logic [CW-1:0]  cnt_q;
    logic [RW-1:0]  row_q;
    logic [SW-1:0]  sh_q;
    logic [PCW-1:0] per_q;
    logic [DW-1:0]  base_q;

    logic           legal, start, per_last;
    logic [RW-1:0]  cand_row;
    logic [CW-1:0]  cand_cnt;

    assign legal    = chg_up_i ? (int'(cnt_q) < NPH) : (int'(cnt_q) > 1);
    assign cand_cnt = pend_up_q ? cnt_q + CW'(1) : cnt_q - CW'(1);
    assign cand_row = RW'(trans_row(pend_up_q, int'(cnt_q), NPH));
    assign start    = tick_i && (st_q == WIN_IDLE) && pend_q;
    assign per_last = (int'(per_q) == (1 << sh_q) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= WIN_IDLE;
            pend_q    <= 1'b0;
            pend_up_q <= 1'b0;
            cnt_q     <= CW'(1);
            row_q     <= '0;
            sh_q      <= '0;
            per_q     <= '0;
            base_q    <= '0;
        end else if (start) begin
            pend_q <= 1'b0;
            cnt_q  <= cand_cnt;
            row_q  <= cand_row;
            sh_q   <= fit_sh_i;
            per_q  <= '0;
            base_q <= dss_i;
            st_q   <= WIN_RUN;
        end else begin
            if (chg_i && !pend_q && legal) begin
                pend_q    <= 1'b1;
                pend_up_q <= chg_up_i;
            end
            if (st_q == WIN_RUN && tick_i) begin
                if (per_last) st_q  <= WIN_IDLE;
                else          per_q <= per_q + PCW'(1);
            end
        end
    end

    assign cnt_o      = cnt_q;
    assign cand_cnt_o = cand_cnt;
    assign run_o      = (st_q == WIN_RUN);
    assign row_o      = run_o ? row_q : cand_row;
    assign sh_o       = sh_q;
    assign last_o     = per_last;
    assign base_o     = base_q;
endmodule

// File: rtl/deq_lane.sv
module deq_lane
    import deq_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int DW    = 10,
    parameter int OW    = 10,
    parameter int CW    = 3,
    parameter int SW    = 2,
    parameter int MAXSH = 2
) (
    input  logic signed [OW-1:0] off_i,
    input  logic [DW-1:0]        dss_i,
    input  logic [DW-1:0]        base_i,
    input  logic                 run_i,
    input  logic [SW-1:0]        sh_i,
    input  logic                 last_i,
    input  logic [CW-1:0]        cnt_i,
    input  logic [CW-1:0]        cand_cnt_i,
    output logic [MAXSH:0]       fit_ok_o,
    output logic [DW-1:0]        duty_o
);
    localparam int DMAX = (1 << DW) - 1;

    for (genvar s = 0; s <= MAXSH; s++) begin : g_fit
        assign fit_ok_o[s] = (IDX >= int'(cand_cnt_i)) ||
                             (int'(dss_i) + (int'(off_i) >>> s) >= 0);
    end

    int share, rem, add;

    always_comb begin
        share = int'(off_i) >>> sh_i;
        rem   = int'(off_i) - ((1 << sh_i) - 1) * share;
        add   = last_i ? rem : share;
        if (IDX >= int'(cnt_i))
            duty_o = '0;
        else if (run_i)
            duty_o = DW'(clamp_duty(int'(base_i) + add, DMAX));
        else
            duty_o = dss_i;
    end
endmodule

// File: rtl/duty_equaliser.sv
module duty_equaliser #(
    parameter int  NPH   = 4,
    parameter int  DW    = 10,
    parameter int  OW    = 10,
    parameter int  MAXSH = 2,
    localparam int CW    = $clog2(NPH + 1),
    localparam int PW    = (NPH < 2) ? 1 : $clog2(NPH),
    localparam int NTR   = 2 * (NPH - 1),
    localparam int RW    = (NTR < 2) ? 1 : $clog2(NTR),
    localparam int SW    = (MAXSH < 1) ? 1 : $clog2(MAXSH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwm_tick_i,
    input  logic [DW-1:0]       dss_i,
    input  logic                chg_i,
    input  logic                chg_up_i,
    input  logic                tbl_we_i,
    input  logic [RW-1:0]       tbl_row_i,
    input  logic [PW-1:0]       tbl_ph_i,
    input  logic [OW-1:0]       tbl_val_i,
    output logic [NPH*DW-1:0]   duty_o,
    output logic [CW-1:0]       ph_cnt_o
);
    logic [NPH*OW-1:0] row_data;
    logic [RW-1:0]     rd_row;
    logic [CW-1:0]     cand_cnt;
    logic              win_run, win_last;
    logic [SW-1:0]     win_sh, fit_sh;
    logic [DW-1:0]     win_base;
    logic [MAXSH:0]    lane_ok [NPH];
    logic [MAXSH:0]    all_ok;

    deq_table #(.NPH(NPH), .OW(OW), .NTR(NTR), .RW(RW), .PW(PW)) u_table (
        .clk(clk), .rst(rst), .we_i(tbl_we_i), .wr_row_i(tbl_row_i),
        .wr_ph_i(tbl_ph_i), .wr_val_i(tbl_val_i), .rd_row_i(rd_row),
        .rd_data_o(row_data)
    );

    deq_ctrl #(.NPH(NPH), .DW(DW), .CW(CW), .RW(RW), .SW(SW), .MAXSH(MAXSH)) u_ctrl (
        .clk(clk), .rst(rst), .tick_i(pwm_tick_i), .chg_i(chg_i),
        .chg_up_i(chg_up_i), .dss_i(dss_i), .fit_sh_i(fit_sh),
        .cnt_o(ph_cnt_o), .cand_cnt_o(cand_cnt), .row_o(rd_row),
        .run_o(win_run), .sh_o(win_sh), .last_o(win_last), .base_o(win_base)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_lane
        deq_lane #(.IDX(p), .DW(DW), .OW(OW), .CW(CW), .SW(SW), .MAXSH(MAXSH)) u_lane (
            .off_i(row_data[p*OW +: OW]), .dss_i(dss_i), .base_i(win_base),
            .run_i(win_run), .sh_i(win_sh), .last_i(win_last),
            .cnt_i(ph_cnt_o), .cand_cnt_i(cand_cnt),
            .fit_ok_o(lane_ok[p]), .duty_o(duty_o[p*DW +: DW])
        );
    end

    always_comb begin
        all_ok = '1;
        for (int p = 0; p < NPH; p++) all_ok &= lane_ok[p];
    end

    always_comb begin
        fit_sh = SW'(MAXSH);
        for (int s = MAXSH; s >= 0; s--)
            if (all_ok[s]) fit_sh = SW'(s);
    end
endmodule

// File: rtl/deq_chk.sv
module deq_chk #(
    parameter int NPH = 4,
    parameter int DW  = 10,
    parameter int CW  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              run_i,
    input logic [DW-1:0]     dss_i,
    input logic [NPH*DW-1:0] duty_i,
    input logic [CW-1:0]     ph_cnt_i
);
    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(ph_cnt_i) >= 1) && (int'(ph_cnt_i) <= NPH));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_cnt_i != $past(ph_cnt_i)) |->
            ((ph_cnt_i == $past(ph_cnt_i) + CW'(1)) || (ph_cnt_i == $past(ph_cnt_i) - CW'(1))));

    // R3
    cnt_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_cnt_i != $past(ph_cnt_i)) |-> $past(tick_i));

    // R8
    win_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !tick_i) |=> run_i);

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        // R2
        passthru_chk: assert property (@(posedge clk) disable iff (rst)
            (!run_i && (p < int'(ph_cnt_i))) |-> (duty_i[p*DW +: DW] == dss_i));

        // R2
        off_phase_chk: assert property (@(posedge clk) disable iff (rst)
            (p >= int'(ph_cnt_i)) |-> (duty_i[p*DW +: DW] == '0));
    end
endmodule

bind duty_equaliser deq_chk #(.NPH(NPH), .DW(DW), .CW(CW)) u_deq_chk (
    .clk(clk), .rst(rst), .tick_i(pwm_tick_i), .run_i(win_run),
    .dss_i(dss_i), .duty_i(duty_o), .ph_cnt_i(ph_cnt_o)
);

// File: tb/duty_equaliser_test.sv
module duty_equaliser_test;
    localparam int CLK_P = 10;
    localparam int NPH   = 4;
    localparam int DW    = 10;
    localparam int OW    = 10;
    localparam int MAXSH = 2;
    localparam int CW    = 3;
    localparam int PW    = 2;
    localparam int NTR   = 6;
    localparam int RW    = 3;
    localparam int DMAX  = (1 << DW) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pwm_tick_i = 1'b0;
    logic [DW-1:0]     dss_i = '0;
    logic              chg_i = 1'b0;
    logic              chg_up_i = 1'b0;
    logic              tbl_we_i = 1'b0;
    logic [RW-1:0]     tbl_row_i = '0;
    logic [PW-1:0]     tbl_ph_i = '0;
    logic [OW-1:0]     tbl_val_i = '0;
    logic [NPH*DW-1:0] duty_o;
    logic [CW-1:0]     ph_cnt_o;

    int n_chk = 0;
    int n_bad = 0;
    int cnt_m = 1;
    int tbl_m [NTR][NPH];
    bit reported = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    duty_equaliser #(.NPH(NPH), .DW(DW), .OW(OW), .MAXSH(MAXSH)) uut (
        .clk(clk), .rst(rst), .pwm_tick_i(pwm_tick_i), .dss_i(dss_i),
        .chg_i(chg_i), .chg_up_i(chg_up_i), .tbl_we_i(tbl_we_i),
        .tbl_row_i(tbl_row_i), .tbl_ph_i(tbl_ph_i), .tbl_val_i(tbl_val_i),
        .duty_o(duty_o), .ph_cnt_o(ph_cnt_o)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    task automatic check_eq(int got, int exp, string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int duty_of(int ph);
        return int'(duty_o[ph*DW +: DW]);
    endfunction

    task automatic check_pass(string tag);
        check_eq(int'(ph_cnt_o), cnt_m, {tag, " (count)"});
        for (int ph = 0; ph < NPH; ph++)
            check_eq(duty_of(ph), (ph < cnt_m) ? int'(dss_i) : 0,
                     $sformatf("%s phase %0d", tag, ph));
    endtask

    task automatic pulse_chg(bit up);
        @(negedge clk); chg_i = 1'b1; chg_up_i = up;
        @(negedge clk); chg_i = 1'b0; #1;
    endtask

    task automatic pulse_tick();
        @(negedge clk); pwm_tick_i = 1'b1;
        @(negedge clk); pwm_tick_i = 1'b0; #1;
    endtask

    task automatic wr(int row, int ph, int val);
        @(negedge clk);
        tbl_we_i = 1'b1; tbl_row_i = RW'(row); tbl_ph_i = PW'(ph); tbl_val_i = OW'(val);
        @(negedge clk); tbl_we_i = 1'b0; #1;
        tbl_m[row][ph] = val;
    endtask

    // R4: add rows lift the new phase and lower the old ones; remove rows use a signed trim
    task automatic load_table(bit alt);
        int k, v;
        for (int r = 0; r < NTR; r++) begin
            for (int ph = 0; ph < NPH; ph++) begin
                if (r < NPH - 1) begin
                    k = r + 1;
                    if (ph == k)     v = 90 + 10*k;
                    else if (ph < k) v = alt ? -(41 + 2*k) : -(101 + 2*k);
                    else             v = 200;
                end else begin
                    k = r - (NPH - 1) + 2;
                    if (ph < k - 1)  v = alt ? -(37 + k) : (37 + k);
                    else             v = 500;
                end
                wr(r, ph, v);
            end
        end
    endtask

    task automatic run_window(bit up, int base, bit inject);
        int row, nc, s, n, sh, rem, add, raw, exp;
        bit ok;
        string tag;
        row = up ? cnt_m - 1 : NPH + cnt_m - 3;
        nc  = up ? cnt_m + 1 : cnt_m - 1;
        s   = MAXSH;
        for (int t = MAXSH; t >= 0; t--) begin
            ok = 1'b1;
            for (int ph = 0; ph < nc; ph++)
                if (base + (tbl_m[row][ph] >>> t) < 0) ok = 1'b0;
            if (ok) s = t;
        end
        n = 1 << s;
        dss_i = DW'(base);
        pulse_tick();
        cnt_m = nc;
        dss_i = DW'((base + 7 > DMAX) ? base - 7 : base + 7);
        #1;
        for (int p = 0; p < n; p++) begin
            for (int rep = 0; rep < 2; rep++) begin
                check_eq(int'(ph_cnt_o), nc, "R3 count after opening strobe");
                for (int ph = 0; ph < NPH; ph++) begin
                    sh  = tbl_m[row][ph] >>> s;
                    rem = tbl_m[row][ph] - (n - 1) * sh;
                    add = (p == n - 1) ? rem : sh;
                    raw = base + add;
                    if (ph >= nc)        begin exp = 0;    tag = "R2 stopped phase in window"; end
                    else if (raw < 0)    begin exp = 0;    tag = "R7 floor clamp"; end
                    else if (raw > DMAX) begin exp = DMAX; tag = "R7 ceiling clamp"; end
                    else if (n > 1)      begin exp = raw;  tag = "R6 split share"; end
                    else                 begin exp = raw;  tag = "R5 latched base plus offset"; end
                    check_eq(duty_of(ph), exp,
                             $sformatf("%s%s row %0d period %0d/%0d phase %0d",
                                       rep ? "R8 no strobe, held: " : "", tag, row, p, n, ph));
                end
                if (rep == 0) begin @(negedge clk); @(negedge clk); #1; end
            end
            if (inject && p == n - 1) pulse_chg(1'b1);
            pulse_tick();
        end
        check_pass("R8 back to pass-through");
    endtask

    task automatic do_change(bit up, int dss, bit inject);
        bit legal;
        legal = up ? (cnt_m < NPH) : (cnt_m > 1);
        dss_i = DW'(dss);
        pulse_chg(up);
        check_pass("R3 request waits for strobe");
        if (!legal) begin
            pulse_tick();
            check_pass("R3 out-of-range request dropped");
        end else begin
            run_window(up, dss, inject);
            if (inject) begin
                check_pass("R9 request during window waits");
                run_window(1'b1, int'(dss_i), 1'b0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int dss_set [6] = '{300, 60, 30, 10, 1000, 0};
        for (int r = 0; r < NTR; r++)
            for (int ph = 0; ph < NPH; ph++) tbl_m[r][ph] = 0;
        dss_i = DW'(123);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        check_pass("R1 reset state");

        // R4: cleared table gives zero offsets
        do_change(1'b1, 200, 1'b0);
        do_change(1'b0, 450, 1'b0);

        for (int alt = 0; alt < 2; alt++) begin
            load_table(alt[0]);
            foreach (dss_set[i]) begin
                for (int u = 0; u < NPH; u++) do_change(1'b1, dss_set[i], 1'b0);
                for (int d = 0; d < NPH; d++) do_change(1'b0, dss_set[i], 1'b0);
            end
        end

        // R9: second request while one is pending is dropped
        load_table(1'b0);
        dss_i = DW'(300);
        pulse_chg(1'b1);
        pulse_chg(1'b0);
        check_pass("R9 pending request holds");
        run_window(1'b1, 300, 1'b0);
        do_change(1'b0, 300, 1'b0);

        // R9: request during a split window is deferred
        do_change(1'b1, 60, 1'b1);
        do_change(1'b0, 500, 1'b0);
        do_change(1'b0, 500, 1'b0);

        report();
        $finish;
    end
endmodule